// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block watches the control pins of a four-bank SDRAM. On every rising clock edge it reads the pins and turns them into one command code. It keeps track of which banks hold an open row, which low-power mode the device is in, and whether the device has been initialised. It raises an error flag when a command breaks a sequencing rule. These rules cover commands that need every bank precharged, the quiet window after a mode-register load, an auto-precharge burst that is still running, and the reinitialisation that is required after deep power-down.

The monitor sits next to a memory controller or on a bus-trace path. It drives nothing back to the memory. The command seen at one edge is reported on the outputs after that same edge, together with the bank and row state it leaves behind. The burst length and the length of the post-load window are parameters. The bank count comes from the width of the bank-select field.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With both clock-enable samples high, the pins {cs_n,ras_n,cas_n,we_n} decode as follows:
  - cs_n high → deselect (code 1)
  - LHHH → NOP (0)
  - LLHH → row activate (2)
  - LHLH → read (3)
  - LHLL → write (4)
  - LLHL → precharge, giving 5 with a10_ap low and 6 with a10_ap high
  - LLLH → auto refresh (7)
  - LLLL → mode-register load (8)
  - LHHL → burst stop (9)

  The code sampled at edge k is shown on cmd_code after edge k.
- R2: For activate, read, write and single-bank precharge, cmd_bank equals the sampled ba; for every other command it is 0. bank_open bit i means bank i (ba = i) holds an open row.
- R3: Precharge with a10_ap high closes every bank whatever ba carries. With a10_ap low it closes only bank ba.
- R4: cmd_ap equals a10_ap for read and write and is 0 for every other command.
- R5: An error is raised in these cases: activate to an open bank, read or write to an idle bank, and activate, read or write while the device is uninitialised. An erroneous command is still reported but changes no bank, mode or timer state.
- R6: Mode-register load, auto refresh and self-refresh entry are errors unless every bank is idle.
- R7: After an accepted mode-register load at edge k, any command other than NOP or deselect sampled at edge k+1 or k+2 is an error.
- R8: After an accepted read or write with auto precharge at edge k, any read or write at edges k+1 to k+BURST_LEN-1 is an error, whatever its bank. The burst's bank reads idle from edge k+BURST_LEN-1 onwards. A later single-bank precharge of that bank, or a precharge of all banks, cancels the pending close.
- R9: Clock enable falling (cke_prev=1, cke_cur=0) decodes as follows:
  - refresh pattern → self-refresh entry (10)
  - NOP or deselect → power-down entry (12)
  - burst-stop pattern → deep power-down entry (14)

  Clock enable rising leaves the current mode: self-refresh exit (11), power-down exit (13) or deep power-down exit (15). Both samples low report hold (16) with no error.
- R10: An accepted deep power-down entry closes every bank. After its exit the device is uninitialised until the next accepted mode-register load.
- R11: After reset: cmd_code 0, cmd_bank 0, cmd_ap 0, cmd_err 0, all banks idle, normal mode, device initialised.
- R12: The following report code 17 with an error:
  - clock enable falling with any other pattern
  - clock enable rising while in normal mode

  Any command sampled with cke_prev high while in a low-power mode is also an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock enable sampled at the previous edge |
| cke_cur | input | 1 | Clock enable at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| a10_ap | input | 1 | Auto-precharge / all-banks address bit |
| cmd_code | output | 5 | Decoded command code |
| cmd_bank | output | BANK_W | Target bank of the decoded command |
| cmd_ap | output | 1 | Auto precharge requested |
| bank_open | output | 2**BANK_W | Per-bank open-row flags |
| cmd_err | output | 1 | Command illegal in the current state |

## Verification
Each result is due one register stage after its stimulus. The command code, bank, auto-precharge flag and error appear just after the edge that sampled the pins, and bank_open reflects that command's effect after the same edge. The timed rules count from the accepting edge:
- The load window covers the next two edges.
- The burst window covers the next BURST_LEN-1 edges.
- The burst's bank closes at edge k+BURST_LEN-1.

The bench drives the pins on the falling edge and compares every output shortly after the next rising edge. It compares them against a behavioural model that advances exactly once per applied command, so every check lands on the cycle its result becomes valid.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [4:0] {
    CMD_NOP      = 5'd0,
    CMD_DESEL    = 5'd1,
    CMD_ACT      = 5'd2,
    CMD_READ     = 5'd3,
    CMD_WRITE    = 5'd4,
    CMD_PRE      = 5'd5,
    CMD_PREALL   = 5'd6,
    CMD_AREF     = 5'd7,
    CMD_MRS      = 5'd8,
    CMD_BST      = 5'd9,
    CMD_SREF_IN  = 5'd10,
    CMD_SREF_OUT = 5'd11,
    CMD_PDN_IN   = 5'd12,
    CMD_PDN_OUT  = 5'd13,
    CMD_DPD_IN   = 5'd14,
    CMD_DPD_OUT  = 5'd15,
    CMD_HOLD     = 5'd16,
    CMD_BAD      = 5'd17
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_SREF = 2'd1,
    MODE_PDN  = 2'd2,
    MODE_DPD  = 2'd3
  } mode_e;

  function automatic logic uses_bank(cmd_e c);
    return (c == CMD_ACT) || (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_PRE);
  endfunction

  function automatic logic is_access(cmd_e c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction

  function automatic logic is_quiet(cmd_e c);
    return (c == CMD_NOP) || (c == CMD_DESEL);
  endfunction

  function automatic logic needs_all_idle(cmd_e c);
    return (c == CMD_MRS) || (c == CMD_AREF) || (c == CMD_SREF_IN);
  endfunction

  function automatic logic is_wake(cmd_e c);
    return (c == CMD_SREF_OUT) || (c == CMD_PDN_OUT) || (c == CMD_DPD_OUT) || (c == CMD_HOLD);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cke_prev,
  input  logic              cke_cur,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba_in,
  input  logic              ap_in,
  input  mode_e             mode,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank,
  output logic              ap
);
  logic [2:0] rcw;
  assign rcw = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = CMD_BAD;
    case ({cke_prev, cke_cur})
      2'b11: begin
        if (cs_n) cmd = CMD_DESEL;
        else begin
          case (rcw)
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_READ;
            3'b100:  cmd = CMD_WRITE;
            3'b010:  cmd = ap_in ? CMD_PREALL : CMD_PRE;
            3'b001:  cmd = CMD_AREF;
            3'b000:  cmd = CMD_MRS;
            default: cmd = CMD_BST;
          endcase
        end
      end
      2'b10: begin
        if (cs_n || rcw == 3'b111) cmd = CMD_PDN_IN;
        else if (rcw == 3'b001)    cmd = CMD_SREF_IN;
        else if (rcw == 3'b110)    cmd = CMD_DPD_IN;
        else                       cmd = CMD_BAD;
      end
      2'b01: begin
        case (mode)
          MODE_SREF: cmd = CMD_SREF_OUT;
          MODE_PDN:  cmd = CMD_PDN_OUT;
          MODE_DPD:  cmd = CMD_DPD_OUT;
          default:   cmd = CMD_BAD;
        endcase
      end
      default: cmd = CMD_HOLD;
    endcase
    bank = uses_bank(cmd) ? ba_in : '0;
    ap   = is_access(cmd) & ap_in;
  end
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] open_i,
  input  mode_e                mode,
  input  logic                 init_ok,
  input  logic                 mrs_busy,
  input  logic                 ap_busy,
  output logic                 err
);
  logic bad_mode, bad_gap, bad_init, bad_bank, bad_idle, bad_burst;

  assign bad_mode  = (mode != MODE_RUN) && !is_wake(cmd);
  assign bad_gap   = mrs_busy && !is_quiet(cmd);
  assign bad_init  = !init_ok && (cmd == CMD_ACT || is_access(cmd));
  assign bad_bank  = (cmd == CMD_ACT && open_i[bank]) || (is_access(cmd) && !open_i[bank]);
  assign bad_idle  = needs_all_idle(cmd) && (|open_i);
  assign bad_burst = is_access(cmd) && ap_busy;

  assign err = (cmd == CMD_BAD) | bad_mode | bad_gap | bad_init | bad_bank | bad_idle | bad_burst;
endmodule

// File: rtl/sdram_dev_state.sv
module sdram_dev_state
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int MRS_GAP   = 2,
  localparam int AP_CW    = $clog2(BURST_LEN),
  localparam int MRS_CW   = $clog2(MRS_GAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap,
  input  logic              ok,
  output mode_e             mode,
  output logic              init_ok,
  output logic              mrs_busy,
  output logic              ap_busy,
  output logic              ap_close,
  output logic [BANK_W-1:0] ap_bank
);
  logic [MRS_CW-1:0] mrs_cnt;
  logic [AP_CW-1:0]  ap_cnt;

  assign mrs_busy = (mrs_cnt != '0);
  assign ap_busy  = (ap_cnt != '0);
  assign ap_close = (ap_cnt == AP_CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RUN;
      init_ok <= 1'b1;
      mrs_cnt <= '0;
      ap_cnt  <= '0;
      ap_bank <= '0;
    end else begin
      if (mrs_busy) mrs_cnt <= mrs_cnt - 1'b1;
      if (ap_busy)  ap_cnt  <= ap_cnt - 1'b1;
      if (ok) begin
        case (cmd)
          CMD_MRS: begin
            init_ok <= 1'b1;
            mrs_cnt <= MRS_CW'(MRS_GAP);
          end
          CMD_READ, CMD_WRITE: if (ap) begin
            ap_cnt  <= AP_CW'(BURST_LEN - 1);
            ap_bank <= bank;
          end
          CMD_PRE:      if (bank == ap_bank) ap_cnt <= '0;
          CMD_PREALL:   ap_cnt <= '0;
          CMD_SREF_IN:  mode <= MODE_SREF;
          CMD_PDN_IN:   mode <= MODE_PDN;
          CMD_DPD_IN: begin
            mode   <= MODE_DPD;
            ap_cnt <= '0;
          end
          CMD_SREF_OUT, CMD_PDN_OUT: mode <= MODE_RUN;
          CMD_DPD_OUT: begin
            mode    <= MODE_RUN;
            init_ok <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 ok,
  input  logic                 ap_close,
  input  logic [BANK_W-1:0]    ap_bank,
  output logic [NUM_BANKS-1:0] open_q
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit, set_row, clr_row;
    assign hit     = (bank == BANK_W'(i));
    assign set_row = ok && (cmd == CMD_ACT) && hit;
    assign clr_row = (ok && ((cmd == CMD_PREALL) || (cmd == CMD_DPD_IN) || (cmd == CMD_PRE && hit)))
                   || (ap_close && ap_bank == BANK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q[i] <= 1'b0;
      else if (set_row) open_q[i] <= 1'b1;
      else if (clr_row) open_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int MRS_GAP   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_prev,
  input  logic                      cke_cur,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BANK_W-1:0]         ba,
  input  logic                      a10_ap,
  output logic [4:0]                cmd_code,
  output logic [BANK_W-1:0]         cmd_bank,
  output logic                      cmd_ap,
  output logic [(1<<BANK_W)-1:0]    bank_open,
  output logic                      cmd_err
);
  localparam int NUM_BANKS = 1 << BANK_W;

  cmd_e              dec_cmd;
  logic [BANK_W-1:0] dec_bank;
  logic              dec_ap;
  logic              dec_err;
  logic              cmd_ok;
  mode_e             mode;
  logic              init_ok, mrs_busy, ap_busy, ap_close;
  logic [BANK_W-1:0] ap_bank;
  logic [NUM_BANKS-1:0] open_now;

  assign cmd_ok    = !dec_err;
  assign bank_open = open_now;

  sdram_cmd_decode #(.BANK_W(BANK_W)) u_dec (
    .cke_prev(cke_prev), .cke_cur(cke_cur), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba_in(ba), .ap_in(a10_ap), .mode(mode),
    .cmd(dec_cmd), .bank(dec_bank), .ap(dec_ap)
  );

  sdram_rule_check #(.BANK_W(BANK_W)) u_rule (
    .cmd(dec_cmd), .bank(dec_bank), .open_i(open_now), .mode(mode),
    .init_ok(init_ok), .mrs_busy(mrs_busy), .ap_busy(ap_busy), .err(dec_err)
  );

  sdram_dev_state #(.BANK_W(BANK_W), .BURST_LEN(BURST_LEN), .MRS_GAP(MRS_GAP)) u_dev (
    .clk(clk), .rst_n(rst_n), .cmd(dec_cmd), .bank(dec_bank), .ap(dec_ap), .ok(cmd_ok),
    .mode(mode), .init_ok(init_ok), .mrs_busy(mrs_busy), .ap_busy(ap_busy),
    .ap_close(ap_close), .ap_bank(ap_bank)
  );

  sdram_bank_table #(.BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .cmd(dec_cmd), .bank(dec_bank), .ok(cmd_ok),
    .ap_close(ap_close), .ap_bank(ap_bank), .open_q(open_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code <= CMD_NOP;
      cmd_bank <= '0;
      cmd_ap   <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_code <= dec_cmd;
      cmd_bank <= dec_bank;
      cmd_ap   <= dec_ap;
      cmd_err  <= dec_err;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [4:0]             cmd_code,
  input logic [BANK_W-1:0]      cmd_bank,
  input logic                   cmd_ap,
  input logic [(1<<BANK_W)-1:0] bank_open,
  input logic                   cmd_err
);
  assert_ap_only_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_code inside {CMD_READ, CMD_WRITE}) |-> !cmd_ap);

  assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT && !cmd_err) |-> bank_open[cmd_bank]);

  assert_access_needs_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code inside {CMD_READ, CMD_WRITE} && !cmd_err) |-> bank_open[cmd_bank]);

  assert_preall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PREALL && !cmd_err) |-> (bank_open == '0));

  assert_mrs_all_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_MRS && !cmd_err) |-> ($past(bank_open) == '0));

  assert_mrs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_code) == CMD_MRS && !$past(cmd_err) && !(cmd_code inside {CMD_NOP, CMD_DESEL}))
      |-> cmd_err);

  assert_burst_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_code inside {CMD_READ, CMD_WRITE}) && $past(cmd_ap) && !$past(cmd_err)
      && (cmd_code inside {CMD_READ, CMD_WRITE})) |-> cmd_err);

  assert_deep_pd_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_DPD_IN && !cmd_err) |-> (bank_open == '0));

  assert_bad_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_BAD) |-> cmd_err);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .cmd_ap(cmd_ap), .bank_open(bank_open), .cmd_err(cmd_err)
);

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;
  localparam int BL = 4;
  localparam int C_NOP = 0, C_DESEL = 1, C_ACT = 2, C_RD = 3, C_WR = 4, C_PRE = 5,
                 C_PREALL = 6, C_AREF = 7, C_MRS = 8, C_BST = 9, C_SREF_IN = 10,
                 C_SREF_OUT = 11, C_PDN_IN = 12, C_PDN_OUT = 13, C_DPD_IN = 14,
                 C_DPD_OUT = 15, C_HOLD = 16, C_BAD = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_prev = 1'b1, cke_cur = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10_ap = 1'b0;
  logic [4:0] cmd_code;
  logic [1:0] cmd_bank;
  logic cmd_ap, cmd_err;
  logic [3:0] bank_open;

  int vectors = 0, misses = 0;
  bit done = 0;

  // reference state
  int m_mode = 0, m_mrs = 0, m_ap = 0, m_apb = 0;
  bit m_init = 1;
  bit [3:0] m_open = '0;
  int e_code, e_bank;
  bit e_ap, e_err;

  always #2 clk = ~clk;

  sdram_cmd_monitor #(.BANK_W(2), .BURST_LEN(BL), .MRS_GAP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_cur(cke_cur), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10_ap(a10_ap),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .bank_open(bank_open), .cmd_err(cmd_err)
  );

  task automatic model(input bit cp, cc, cs, r, c, w, input int b, input bit a);
    int code;
    bit e;
    bit [2:0] p;
    p = {r, c, w};
    if (cp && cc) begin
      if (cs) code = C_DESEL;
      else case (p)
        3'b111: code = C_NOP;
        3'b011: code = C_ACT;
        3'b101: code = C_RD;
        3'b100: code = C_WR;
        3'b010: code = a ? C_PREALL : C_PRE;
        3'b001: code = C_AREF;
        3'b000: code = C_MRS;
        default: code = C_BST;
      endcase
    end else if (cp) begin
      if (cs || p == 3'b111) code = C_PDN_IN;
      else if (p == 3'b001) code = C_SREF_IN;
      else if (p == 3'b110) code = C_DPD_IN;
      else code = C_BAD;
    end else if (cc) begin
      code = (m_mode == 1) ? C_SREF_OUT : (m_mode == 2) ? C_PDN_OUT :
             (m_mode == 3) ? C_DPD_OUT : C_BAD;
    end else code = C_HOLD;

    e_code = code;
    e_bank = (code == C_ACT || code == C_RD || code == C_WR || code == C_PRE) ? b : 0;
    e_ap   = (code == C_RD || code == C_WR) ? a : 1'b0;
    e = (code == C_BAD);
    if (m_mode != 0 && !(code == C_SREF_OUT || code == C_PDN_OUT || code == C_DPD_OUT || code == C_HOLD)) e = 1;
    if (m_mrs > 0 && !(code == C_NOP || code == C_DESEL)) e = 1;
    if (!m_init && (code == C_ACT || code == C_RD || code == C_WR)) e = 1;
    if (code == C_ACT && m_open[b]) e = 1;
    if ((code == C_RD || code == C_WR) && (!m_open[b] || m_ap > 0)) e = 1;
    if ((code == C_MRS || code == C_AREF || code == C_SREF_IN) && m_open != 0) e = 1;
    e_err = e;

    if (m_ap == 1) m_open[m_apb] = 1'b0;
    if (m_mrs > 0) m_mrs--;
    if (m_ap > 0) m_ap--;
    if (!e) begin
      case (code)
        C_ACT: m_open[b] = 1'b1;
        C_PRE: begin m_open[b] = 1'b0; if (b == m_apb) m_ap = 0; end
        C_PREALL: begin m_open = '0; m_ap = 0; end
        C_MRS: begin m_init = 1; m_mrs = 2; end
        C_RD, C_WR: if (a) begin m_ap = BL - 1; m_apb = b; end
        C_SREF_IN: m_mode = 1;
        C_PDN_IN: m_mode = 2;
        C_DPD_IN: begin m_mode = 3; m_open = '0; m_ap = 0; end
        C_SREF_OUT, C_PDN_OUT: m_mode = 0;
        C_DPD_OUT: begin m_mode = 0; m_init = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic apply(input bit cp, cc, cs, r, c, w, input int b, input bit a, input string tag);
    @(negedge clk);
    cke_prev = cp; cke_cur = cc; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
    ba = 2'(b); a10_ap = a;
    model(cp, cc, cs, r, c, w, b, a);
    @(posedge clk);
    #1;
    vectors++;
    if (cmd_code !== 5'(e_code) || cmd_bank !== 2'(e_bank) || cmd_ap !== e_ap ||
        cmd_err !== e_err || bank_open !== m_open) begin
      misses++;
      $display("FAIL %s: actual code=%0d bank=%0d ap=%0b err=%0b open=%b expected code=%0d bank=%0d ap=%0b err=%0b open=%b",
               tag, cmd_code, cmd_bank, cmd_ap, cmd_err, bank_open,
               e_code, e_bank, e_ap, e_err, m_open);
    end
  endtask

  task automatic cmd(input bit cs, r, c, w, input int b, input bit a, input string t);
    apply(1, 1, cs, r, c, w, b, a, t);
  endtask
  task automatic nop(input string t);             cmd(0, 1, 1, 1, 0, 0, t); endtask
  task automatic act(input int b, input string t); cmd(0, 0, 1, 1, b, 0, t); endtask
  task automatic rd(input int b, input bit a, input string t); cmd(0, 1, 0, 1, b, a, t); endtask
  task automatic wr(input int b, input bit a, input string t); cmd(0, 1, 0, 0, b, a, t); endtask
  task automatic pre(input int b, input string t); cmd(0, 0, 1, 0, b, 0, t); endtask
  task automatic preall(input int b, input string t); cmd(0, 0, 1, 0, b, 1, t); endtask
  task automatic mrs(input string t);             cmd(0, 0, 0, 0, 0, 0, t); endtask
  task automatic hold(input string t);            apply(0, 0, 1, 1, 1, 1, 0, 0, t); endtask
  task automatic wake(input string t);            apply(0, 1, 1, 1, 1, 1, 0, 0, t); endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    vectors++;
    if (cmd_code !== 5'd0 || cmd_bank !== 2'd0 || cmd_ap !== 1'b0 || cmd_err !== 1'b0 || bank_open !== 4'b0) begin
      misses++;
      $display("FAIL R11 reset: actual code=%0d bank=%0d ap=%0b err=%0b open=%b expected all zero",
               cmd_code, cmd_bank, cmd_ap, cmd_err, bank_open);
    end
    nop("R1 nop");
    cmd(1, 0, 0, 0, 0, 0, "R1 deselect");
    cmd(0, 1, 1, 0, 0, 0, "R1 burst stop");
    for (int i = 0; i < 4; i++) act(i, "R2 bank map");
    act(1, "R5 act open bank");
    rd(2, 0, "R4 read no ap");
    wr(3, 0, "R4 write no ap");
    pre(1, "R3 single precharge");
    rd(1, 0, "R5 read idle bank");
    preall(2, "R3 precharge all");
    cmd(0, 0, 0, 1, 0, 0, "R6 refresh idle");
    mrs("R7 load");
    act(0, "R7 gap edge1");
    nop("R7 gap nop");
    act(0, "R7 after gap");
    mrs("R6 load with open bank");
    cmd(0, 0, 0, 1, 0, 0, "R6 refresh with open bank");
    apply(1, 0, 0, 0, 0, 1, 0, 0, "R6 self refresh with open bank");
    pre(0, "R3 close");
    mrs("R7 load2");
    nop("R7 nop");
    act(2, "R7 gap edge2");
    act(2, "R7 after gap2");
    act(0, "R8 setup");
    rd(0, 1, "R8 read ap");
    wr(2, 0, "R8 other bank in burst");
    nop("R8 wait");
    nop("R8 close edge");
    rd(2, 0, "R8 after burst");
    act(0, "R8 reopen closed bank");
    wr(0, 1, "R8 write ap");
    pre(0, "R8 cancel by precharge");
    act(0, "R8 reopen after cancel");
    nop("R8 past old close");
    preall(0, "R3 clear");
    apply(1, 0, 0, 0, 0, 1, 0, 0, "R9 self refresh in");
    hold("R9 hold");
    act(1, "R12 cmd in self refresh");
    wake("R9 self refresh out");
    act(2, "R9 setup pdn");
    apply(1, 0, 1, 1, 1, 1, 0, 0, "R9 power down in");
    hold("R9 hold pdn");
    wake("R9 power down out");
    apply(1, 0, 0, 1, 1, 0, 0, 0, "R10 deep pd in");
    hold("R10 hold");
    wake("R10 deep pd out");
    act(1, "R10 act uninit");
    preall(0, "R10 precharge");
    mrs("R10 reinit");
    nop("R10 gap"); nop("R10 gap");
    act(1, "R10 act after init");
    apply(1, 0, 0, 0, 1, 1, 0, 0, "R12 cke fall with act");
    wake("R12 cke rise in run");
    // mixed pins with a consistent clock-enable history
    begin
      bit last = 1;
      for (int n = 0; n < 600; n++) begin
        bit cc;
        cc = ($urandom_range(0, 9) != 0);
        apply(last, cc, $urandom_range(0, 7) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
              $urandom_range(0, 3), 1'($urandom), "R1 mixed");
        last = cc;
      end
    end
    done = 1;
    finish_run();
  end
endmodule